// File: doc/BRIEF.md
# Serial Display Register Access Master

This block gives a host a simple way to read and write 16-bit configuration registers inside an external display controller that listens on a four-wire serial link. The host presents one request at a time through a valid/ready handshake. A request names a register index and says whether it is a write, which also carries 16 bits of data, or a read. The block turns each request into two back-to-back 24-bit frames, with chip select released between them. The first frame always selects the register index. The second frame either writes the value or fetches it.

Each frame starts with a header byte: a device identifier, set at build time, ORed with a two-bit operation code in its low bits. The remaining 16 bits are the payload. Bits leave on the data-out line most significant first. Each bit has a low clock phase, during which the data-out line changes, and a high clock phase. The data-in line is sampled at the end of the low phase. Clock phase length and the chip-select guard time are parameters counted in system clock cycles. When the access finishes, the block raises a one-cycle completion pulse. For a read, the returned register value is presented on that same cycle.

Top module: `lcd_reg_spi_master`

## Requirements
- R1: Out of reset and whenever no access is in progress, chip select, serial clock and data-out are all high, `req_ready` is high and `done` is low.
- R2: Every frame contains exactly 24 serial clock rising edges and is sent most significant bit first. The receiver captures data-out on the rising edge.
- R3: The header byte (frame bits 23:16) equals `DEV_ID` ORed with the operation code. The codes are index select = 0, status read = 1, data write = 2, data read = 3. The first frame of every access uses code 0 and carries the register index, zero-extended, in bits 15:0.
- R4: For a write request, the second frame uses code 2 and carries `req_wdata` in bits 15:0.
- R5: For a read request, the second frame uses code 3 with a zero payload. `rd_data` returns the last 16 bits sampled from data-in during that frame, first-sampled bit most significant, and ignores the upper 8 sampled bits.
- R6: Data-out changes only while the serial clock is low or chip select is high. Each clock phase lasts `HALF_CYC` cycles, and data-in is sampled at the end of the low phase.
- R7: Chip select falls `GUARD_CYC` cycles before the first serial clock fall of a frame. Between the two frames of an access it stays high for `GUARD_CYC`+1 cycles. The serial clock is never low while chip select is high.
- R8: A request is accepted only on a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the access ends, and a request presented during that time produces no frames.
- R9: `done` is a single-cycle pulse on the clock edge 4·`GUARD_CYC`+96·`HALF_CYC`+1 edges after the acceptance edge. On a write, `rd_data` is zero in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_index | input | IDX_W | Register index |
| req_wdata | input | 16 | Value to write |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid with `done` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_mosi | output | 1 | Serial data to the display controller |
| spi_miso | input | 1 | Serial data from the display controller |

## Verification
The bench builds the block with `HALF_CYC`=2, `GUARD_CYC`=3 and `DEV_ID`=8'h74. Because the two counts differ, a guard interval cannot be mistaken for a clock phase in the lead, gap and latency measurements. With a half period of two cycles, the update of data-out and the sampling of data-in fall in different cycles. The identifier has its two low bits clear, so every operation code appears unaltered in the captured header byte. A full access then takes about two hundred cycles, which keeps a table of reads and writes plus the busy-request and reset tests short.

// File: rtl/lrs_pkg.sv
`timescale 1ns/1ps
package lrs_pkg;
    localparam int FRAME_W   = 24;
    localparam int PAYLOAD_W = 16;
    localparam int HDR_W     = FRAME_W - PAYLOAD_W;
    localparam int BITN_W    = $clog2(FRAME_W);

    localparam logic [1:0] OP_INDEX  = 2'd0;
    localparam logic [1:0] OP_STATUS = 2'd1;
    localparam logic [1:0] OP_WRITE  = 2'd2;
    localparam logic [1:0] OP_READ   = 2'd3;

    typedef enum logic [2:0] {
        SH_IDLE, SH_LEAD, SH_LOW, SH_HIGH, SH_TRAIL
    } sh_state_e;

    typedef enum logic [1:0] {
        TP_IDLE, TP_INDEX, TP_GAP, TP_DATA
    } tp_state_e;

    typedef struct packed {
        sh_state_e            st;
        logic [FRAME_W-1:0]   sreg;
        logic [BITN_W-1:0]    bitn;
        logic                 cs_n;
        logic                 sclk;
        logic                 mosi;
    } sh_regs_t;
endpackage

// File: rtl/lrs_interval_timer.sv
`timescale 1ns/1ps
module lrs_interval_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/lrs_frame_shifter.sv
`timescale 1ns/1ps
module lrs_frame_shifter
    import lrs_pkg::*;
#(
    parameter int HALF_CYC  = 2,
    parameter int GUARD_CYC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_word,
    input  logic               miso,
    output logic               cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               frame_done,
    output logic [FRAME_W-1:0] rx_word
);
    localparam int MAXC = (HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0]     HALF_LD  = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0]     GUARD_LD = CW'(GUARD_CYC - 1);
    localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(FRAME_W - 1);

    sh_regs_t r_d, r_q;
    logic          t_load;
    logic [CW-1:0] t_val;
    logic          t_exp;

    lrs_interval_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    always_comb begin
        r_d        = r_q;
        t_load     = 1'b0;
        t_val      = '0;
        frame_done = 1'b0;
        unique case (r_q.st)
            SH_IDLE: if (start) begin
                r_d.st   = SH_LEAD;
                r_d.sreg = tx_word;
                r_d.bitn = '0;
                r_d.cs_n = 1'b0;
                t_load   = 1'b1;
                t_val    = GUARD_LD;
            end
            SH_LEAD: if (t_exp) begin
                r_d.st   = SH_LOW;
                r_d.sclk = 1'b0;
                r_d.mosi = r_q.sreg[FRAME_W-1];
                t_load   = 1'b1;
                t_val    = HALF_LD;
            end
            SH_LOW: if (t_exp) begin
                r_d.st   = SH_HIGH;
                r_d.sreg = {r_q.sreg[FRAME_W-2:0], miso};
                r_d.sclk = 1'b1;
                t_load   = 1'b1;
                t_val    = HALF_LD;
            end
            SH_HIGH: if (t_exp) begin
                t_load = 1'b1;
                if (r_q.bitn == LAST_BIT) begin
                    r_d.st   = SH_TRAIL;
                    r_d.cs_n = 1'b1;
                    r_d.mosi = 1'b1;
                    t_val    = GUARD_LD;
                end else begin
                    r_d.st   = SH_LOW;
                    r_d.bitn = r_q.bitn + 1'b1;
                    r_d.sclk = 1'b0;
                    r_d.mosi = r_q.sreg[FRAME_W-1];
                    t_val    = HALF_LD;
                end
            end
            SH_TRAIL: if (t_exp) begin
                r_d.st     = SH_IDLE;
                frame_done = 1'b1;
            end
            default: r_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= SH_IDLE;
            r_q.sreg <= '0;
            r_q.bitn <= '0;
            r_q.cs_n <= 1'b1;
            r_q.sclk <= 1'b1;
            r_q.mosi <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n    = r_q.cs_n;
    assign sclk    = r_q.sclk;
    assign mosi    = r_q.mosi;
    assign rx_word = r_q.sreg;

    // R6
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sclk && $past(sclk)) |-> $stable(mosi));
    // R7
    sclk_idle_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);
    // R8
    start_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (r_q.st == SH_IDLE));
endmodule

// File: rtl/lcd_reg_spi_master.sv
`timescale 1ns/1ps
module lcd_reg_spi_master
    import lrs_pkg::*;
#(
    parameter logic [7:0] DEV_ID    = 8'h74,
    parameter int         IDX_W     = 8,
    parameter int         HALF_CYC  = 2,
    parameter int         GUARD_CYC = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [IDX_W-1:0]     req_index,
    input  logic [PAYLOAD_W-1:0] req_wdata,
    output logic                 done,
    output logic [PAYLOAD_W-1:0] rd_data,
    output logic                 spi_cs_n,
    output logic                 spi_sclk,
    output logic                 spi_mosi,
    input  logic                 spi_miso
);
    typedef struct packed {
        tp_state_e            st;
        logic                 wr;
        logic [IDX_W-1:0]     idx;
        logic [PAYLOAD_W-1:0] wdat;
        logic                 done;
        logic [PAYLOAD_W-1:0] rdat;
    } tp_regs_t;

    tp_regs_t s_d, s_q;
    logic               sh_start, sh_fdone;
    logic [FRAME_W-1:0] sh_word, sh_rx;

    function automatic logic [HDR_W-1:0] hdr(input logic [1:0] op);
        return DEV_ID | {{(HDR_W-2){1'b0}}, op};
    endfunction

    lrs_frame_shifter #(.HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_word(sh_word),
        .miso(spi_miso), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .frame_done(sh_fdone), .rx_word(sh_rx)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        sh_start = 1'b0;
        sh_word  = '0;
        unique case (s_q.st)
            TP_IDLE: if (req_valid) begin
                sh_start = 1'b1;
                sh_word  = {hdr(OP_INDEX), PAYLOAD_W'(req_index)};
                s_d.wr   = req_write;
                s_d.idx  = req_index;
                s_d.wdat = req_wdata;
                s_d.st   = TP_INDEX;
            end
            TP_INDEX: if (sh_fdone) s_d.st = TP_GAP;
            TP_GAP: begin
                sh_start = 1'b1;
                sh_word  = s_q.wr ? {hdr(OP_WRITE), s_q.wdat}
                                  : {hdr(OP_READ), {PAYLOAD_W{1'b0}}};
                s_d.st   = TP_DATA;
            end
            TP_DATA: if (sh_fdone) begin
                s_d.done = 1'b1;
                s_d.rdat = s_q.wr ? '0 : sh_rx[PAYLOAD_W-1:0];
                s_d.st   = TP_IDLE;
            end
            default: s_d.st = TP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.st == TP_IDLE);
    assign done      = s_q.done;
    assign rd_data   = s_q.rdat;

    // R1
    idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_cs_n && spi_sclk && spi_mosi));
    // R8
    accept_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    done_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);
endmodule

// File: tb/lcd_reg_spi_master_tb.sv
`timescale 1ns/1ps
module lcd_reg_spi_master_tb;
    localparam logic [7:0] DEV   = 8'h74;
    localparam int         HALF  = 2;
    localparam int         GUARD = 3;
    localparam int         FLEN  = 2*GUARD + 48*HALF;
    localparam int         EXP_LAT = 2*FLEN + 2; // negedges counted from the one after acceptance
    localparam int         NVEC  = 6;
    // {write, index, wdata, slave response}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 8'h07, 16'h0015, 16'h0000},
        {1'b1, 8'h5C, 16'hA55A, 16'h1234},
        {1'b0, 8'h00, 16'h0000, 16'h8001},
        {1'b0, 8'hC3, 16'h0000, 16'hFFFF},
        {1'b1, 8'hFF, 16'hFFFF, 16'h0F0F},
        {1'b0, 8'h2A, 16'h0000, 16'h0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, spi_miso = 1'b0;
    logic [7:0] req_index = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, done, spi_cs_n, spi_sclk, spi_mosi;
    logic [15:0] rd_data;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lcd_reg_spi_master #(.DEV_ID(DEV), .IDX_W(8), .HALF_CYC(HALF), .GUARD_CYC(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // serial slave model
    logic [23:0] frames [0:63];
    int          fbits  [0:63];
    int nfr = 0, base = 0, bitc = 0;
    logic [23:0] cap = '0, resp_cur = '0;
    time t_fall = 0, t_rise = 0;
    int lead_cyc = -1, gap_cyc = -1;

    always @(negedge spi_cs_n) if (rst_n) begin
        bitc = 0;
        t_fall = $time;
        if (nfr > base) gap_cyc = int'((t_fall - t_rise) / 8);
    end
    always @(posedge spi_cs_n) if (rst_n) begin
        if (nfr < 64) begin frames[nfr] = cap; fbits[nfr] = bitc; end
        nfr++;
        t_rise = $time;
    end
    always @(negedge spi_sclk) if (rst_n && !spi_cs_n) begin
        if (bitc == 0) lead_cyc = int'(($time - t_fall) / 8);
        if (bitc < 24)
            spi_miso = (nfr == base) ? ~resp_cur[23-bitc] : resp_cur[23-bitc];
    end
    always @(posedge spi_sclk) if (rst_n && !spi_cs_n) begin
        cap = {cap[22:0], spi_mosi};
        bitc++;
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic access(input logic w, input logic [7:0] idx, input logic [15:0] wd,
                          input logic [15:0] rsp, input bit poke);
        int n;
        @(negedge clk);
        base = nfr;
        resp_cur = {8'hA5, rsp};
        req_valid = 1'b1; req_write = w; req_index = idx; req_wdata = wd;
        chk("R8 ready before accept", {31'b0, req_ready}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R8 ready low after accept", {31'b0, req_ready}, 32'd0);
        n = 1;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin req_valid = 1'b1; req_write = 1'b1; req_index = 8'hEE; end
            if (poke && n == 8) chk("R8 ready low while busy", {31'b0, req_ready}, 32'd0);
            if (poke && n == 13) req_valid = 1'b0;
        end
        chk("R9 latency", n, EXP_LAT);
        chk(w ? "R9 rd_data zero on write" : "R5 read data", {16'h0, rd_data}, {16'h0, w ? 16'h0 : rsp});
        chk("R1 idle lines at done", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'd7);
        @(negedge clk);
        chk("R9 done single pulse", {31'b0, done}, 32'd0);
        chk("R8 two frames per access", nfr - base, 32'd2);
        chk("R2 bits in frame 1", fbits[base], 32'd24);
        chk("R2 bits in frame 2", fbits[base+1], 32'd24);
        chk("R3 index frame", {8'h0, frames[base]}, {8'h0, DEV | 8'h00, 8'h00, idx});
        if (w) chk("R4 write frame", {8'h0, frames[base+1]}, {8'h0, DEV | 8'h02, wd});
        else   chk("R5 read frame", {8'h0, frames[base+1]}, {8'h0, DEV | 8'h03, 16'h0});
        chk("R7 lead guard", lead_cyc, GUARD);
        chk("R7 gap between frames", gap_cyc, GUARD + 1);
    endtask

    initial begin
        #(8 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 lines high in reset", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'd7);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1 done low after reset", {31'b0, done}, 32'd0);
        chk("R1 lines high after reset", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'd7);

        for (int i = 0; i < NVEC; i++)
            access(VEC[i][40], VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

        // request presented while busy is not taken (R8)
        access(1'b0, 8'h31, 16'h0, 16'h4321, 1'b1);
        repeat (50) @(negedge clk);
        chk("R8 busy request produced no frames", nfr - base, 32'd2);
        chk("R1 idle after busy poke", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'd7);

        // back-to-back accesses
        access(1'b1, 8'h80, 16'h8000, 16'h0, 1'b0);
        access(1'b0, 8'h01, 16'h0, 16'h0001, 1'b0);

        // reset in the middle of an access returns to idle (R1)
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_index = 8'h10; req_wdata = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 lines high on mid-access reset", {29'b0, spi_cs_n, spi_sclk, spi_mosi}, 32'd7);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after mid-access reset", {31'b0, req_ready}, 32'd1);
        access(1'b0, 8'h22, 16'h0, 16'hC0DE, 1'b0);

        summary();
    end
endmodule